// File: doc/BRIEF.md
# Return Address Prediction Stack

This block sits beside the fetch-stage branch predictor and guesses where a subroutine return will go. Each control transfer seen by the predictor is offered with a valid strobe, a two-bit kind code and the fall-through address of the transferring instruction. A call pushes that fall-through address, which is the same value a call writes to the link register. A return pops the newest address and supplies it as the predicted target. A plain register-indirect jump has the same effect as a return at execution time, but the stack ignores it. Prediction therefore depends only on the kind code and never on which register the branch names.

The storage is a small circular LIFO. When it is full, a further call overwrites the oldest entry and the occupancy stays at its maximum. A return on an empty stack reports no hit. The current pointer and occupancy are always visible on the checkpoint outputs, so the pipeline can capture them alongside a predicted branch. After a misprediction, a single-cycle restore strobe writes those values back. The stored addresses are left as they are.

Top module: `ras_predictor`

## Requirements
- R1: After reset the checkpoint pointer and occupancy outputs are both 0, and no return reports a hit until a call has been recorded.
- R2: With the valid strobe high and kind 2'b01 (call), the fall-through address is written at the current pointer. The pointer then advances by one, wrapping from DEPTH-1 to 0, and the occupancy grows by one.
- R3: With the valid strobe high and kind 2'b10 (return) on a non-empty stack, the hit output is 1 and the target output equals the most recently pushed address not yet popped. On the next edge the pointer steps back by one and the occupancy drops by one, so successive returns see the addresses in reverse push order.
- R4: A return on an empty stack reports hit 0 and leaves the pointer and occupancy unchanged.
- R5: Kind 2'b11 (register-indirect jump that is not a return) and kind 2'b00 (no transfer) push nothing and pop nothing, even with the valid strobe high.
- R6: While the valid strobe is low, no kind code changes the stack.
- R7: Once DEPTH entries are held, a further call overwrites the oldest entry and the occupancy stays at DEPTH. Returns then give back the newest DEPTH addresses and then report a miss.
- R8: A restore strobe loads the pointer and occupancy from the restore inputs on the next edge and leaves the stored addresses untouched. A restore occupancy above DEPTH is taken as DEPTH.
- R9: A restore in the same cycle as a call or return wins. The call writes no entry, and neither transfer moves the pointer. The hit and target outputs of that cycle still reflect the state before the edge.
- R10: The hit and target outputs respond combinationally in the same cycle the return is offered. The hit output is never 1 unless the valid strobe is high with kind 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid_i | input | 1 | A control transfer is offered this cycle |
| xfer_kind_i | input | 2 | 00 none, 01 call, 10 return, 11 register jump |
| link_addr_i | input | AW | Fall-through address of the transfer |
| ret_target_o | output | AW | Predicted return target |
| ret_hit_o | output | 1 | Target is valid for the offered return |
| ckpt_ptr_o | output | PW | Current stack pointer, for checkpointing |
| ckpt_cnt_o | output | CW | Current occupancy, for checkpointing |
| restore_i | input | 1 | Restore pointer and occupancy this cycle |
| restore_ptr_i | input | PW | Pointer to restore |
| restore_cnt_i | input | CW | Occupancy to restore |

## Verification
A checkpoint restore can land in the same cycle as a call or a return, and the restore must override both. The bench provokes this by capturing the checkpoint outputs, moving the stack with further calls, and then raising the restore strobe together with a call carrying a fresh address, and later together with a return. The outcome is judged two ways: the pointer and occupancy must equal the restored values, and the next return must yield the entry that was on top at the checkpoint, not the address offered with the call.

// File: rtl/ras_pkg.sv
package ras_pkg;

    // Kind code of an offered control transfer.
    typedef enum logic [1:0] {
        XK_NONE = 2'b00,
        XK_CALL = 2'b01,
        XK_RET  = 2'b10,
        XK_JUMP = 2'b11
    } xfer_kind_e;

    // Operation applied to the stack state this cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_LOAD = 2'b11
    } stk_op_e;

endpackage

// File: rtl/ras_classify.sv
module ras_classify
    import ras_pkg::*;
(
    input  logic       valid_i,
    input  logic [1:0] kind_i,
    input  logic       restore_i,
    output stk_op_e    op_o,
    output logic       ret_req_o
);

    xfer_kind_e kind;

    always_comb begin
        kind      = xfer_kind_e'(kind_i);
        ret_req_o = valid_i && (kind == XK_RET);
        op_o      = OP_IDLE;
        if (restore_i) begin
            op_o = OP_LOAD;
        end else if (valid_i) begin
            unique case (kind)
                XK_CALL: op_o = OP_PUSH;
                XK_RET:  op_o = OP_POP;
                default: op_o = OP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op_i,
    input  logic [PW-1:0] load_ptr_i,
    input  logic [CW-1:0] load_cnt_i,
    output logic [PW-1:0] ptr_o,
    output logic [CW-1:0] cnt_o,
    output logic [PW-1:0] top_idx_o,
    output logic          empty_o,
    output logic          wr_en_o,
    output logic [PW-1:0] wr_idx_o
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t st_q, st_d;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
        return (p == '0) ? LAST : p - PW'(1);
    endfunction

    always_comb begin
        st_d      = st_q;
        wr_en_o   = 1'b0;
        wr_idx_o  = st_q.ptr;
        empty_o   = (st_q.cnt == '0);
        top_idx_o = ptr_dec(st_q.ptr);
        unique case (op_i)
            OP_PUSH: begin
                wr_en_o    = 1'b1;
                st_d.ptr   = ptr_inc(st_q.ptr);
                st_d.cnt   = (st_q.cnt == FULL) ? FULL : st_q.cnt + CW'(1);
            end
            OP_POP: begin
                if (st_q.cnt != '0) begin
                    st_d.ptr = ptr_dec(st_q.ptr);
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            OP_LOAD: begin
                st_d.ptr = (load_ptr_i > LAST) ? '0 : load_ptr_i;
                st_d.cnt = (load_cnt_i > FULL) ? FULL : load_cnt_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;
    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 64,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_idx_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [AW-1:0] rd_data_o
);

    logic [AW-1:0] ent_q [DEPTH];
    logic [AW-1:0] ent_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
            if (wr_en_i && (wr_idx_i == PW'(i))) ent_d[i] = wr_data_i;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) ent_q[g] <= '0;
            else        ent_q[g] <= ent_d[g];
        end
    end

    assign rd_data_o = ent_q[rd_idx_i];

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 64,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_valid_i,
    input  logic [1:0]    xfer_kind_i,
    input  logic [AW-1:0] link_addr_i,
    output logic [AW-1:0] ret_target_o,
    output logic          ret_hit_o,
    output logic [PW-1:0] ckpt_ptr_o,
    output logic [CW-1:0] ckpt_cnt_o,
    input  logic          restore_i,
    input  logic [PW-1:0] restore_ptr_i,
    input  logic [CW-1:0] restore_cnt_i
);

    stk_op_e       op;
    logic          ret_req;
    logic [PW-1:0] top_idx;
    logic          empty;
    logic          wr_en;
    logic [PW-1:0] wr_idx;

    ras_classify u_cls (
        .valid_i   (xfer_valid_i),
        .kind_i    (xfer_kind_i),
        .restore_i (restore_i),
        .op_o      (op),
        .ret_req_o (ret_req)
    );

    ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .load_ptr_i (restore_ptr_i),
        .load_cnt_i (restore_cnt_i),
        .ptr_o      (ckpt_ptr_o),
        .cnt_o      (ckpt_cnt_o),
        .top_idx_o  (top_idx),
        .empty_o    (empty),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx)
    );

    ras_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (link_addr_i),
        .rd_idx_i  (top_idx),
        .rd_data_o (ret_target_o)
    );

    assign ret_hit_o = ret_req && !empty;

endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 64,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_valid_i,
    input logic [1:0]    xfer_kind_i,
    input logic          ret_hit_o,
    input logic [PW-1:0] ckpt_ptr_o,
    input logic [CW-1:0] ckpt_cnt_o,
    input logic          restore_i,
    input logic [PW-1:0] restore_ptr_i
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    // R2
    push_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_i && xfer_kind_i == 2'b01 && !restore_i) |=>
        (ckpt_ptr_o == (($past(ckpt_ptr_o) == LAST) ? PW'(0) : PW'($past(ckpt_ptr_o) + PW'(1)))));

    // R7
    push_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_i && xfer_kind_i == 2'b01 && !restore_i) |=>
        (ckpt_cnt_o == (($past(ckpt_cnt_o) == FULL) ? FULL : CW'($past(ckpt_cnt_o) + CW'(1)))));

    // R3
    pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_i && xfer_kind_i == 2'b10 && !restore_i && ckpt_cnt_o != '0) |=>
        (ckpt_cnt_o == CW'($past(ckpt_cnt_o) - CW'(1))));

    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_i && xfer_kind_i == 2'b10 && !restore_i && ckpt_cnt_o == '0) |=>
        ($stable(ckpt_ptr_o) && $stable(ckpt_cnt_o)));

    // R4
    empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt_cnt_o == '0) |-> !ret_hit_o);

    // R5
    jump_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_i && (xfer_kind_i == 2'b11 || xfer_kind_i == 2'b00) && !restore_i) |=>
        ($stable(ckpt_ptr_o) && $stable(ckpt_cnt_o)));

    // R6
    idle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_valid_i && !restore_i) |=> ($stable(ckpt_ptr_o) && $stable(ckpt_cnt_o)));

    // R8
    restore_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && restore_ptr_i <= LAST) |=> (ckpt_ptr_o == $past(restore_ptr_i)));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_cnt_o <= FULL);

    // R10
    hit_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_hit_o |-> (xfer_valid_i && xfer_kind_i == 2'b10));

endmodule

bind ras_predictor ras_predictor_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .xfer_valid_i  (xfer_valid_i),
    .xfer_kind_i   (xfer_kind_i),
    .ret_hit_o     (ret_hit_o),
    .ckpt_ptr_o    (ckpt_ptr_o),
    .ckpt_cnt_o    (ckpt_cnt_o),
    .restore_i     (restore_i),
    .restore_ptr_i (restore_ptr_i)
);

// File: tb/ras_predictor_tb_top.sv
`timescale 1ns/1ps
module ras_predictor_tb_top;

    localparam int D  = 8;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xfer_valid_i = 1'b0;
    logic [1:0]    xfer_kind_i = 2'b00;
    logic [AW-1:0] link_addr_i = '0;
    logic [AW-1:0] ret_target_o;
    logic          ret_hit_o;
    logic [2:0]    ckpt_ptr_o;
    logic [3:0]    ckpt_cnt_o;
    logic          restore_i = 1'b0;
    logic [2:0]    restore_ptr_i = '0;
    logic [3:0]    restore_cnt_i = '0;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    logic [AW-1:0] m_mem [D];
    int m_ptr = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    ras_predictor dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_valid_i  (xfer_valid_i),
        .xfer_kind_i   (xfer_kind_i),
        .link_addr_i   (link_addr_i),
        .ret_target_o  (ret_target_o),
        .ret_hit_o     (ret_hit_o),
        .ckpt_ptr_o    (ckpt_ptr_o),
        .ckpt_cnt_o    (ckpt_cnt_o),
        .restore_i     (restore_i),
        .restore_ptr_i (restore_ptr_i),
        .restore_cnt_i (restore_cnt_i)
    );

    task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp,
                         input string tag, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare before the rising edge,
    // then advance the reference model at the rising edge.
    task automatic step(input bit v, input logic [1:0] k, input logic [AW-1:0] a,
                        input bit rs, input int rp, input int rc, input string tag);
        bit exp_hit;
        @(negedge clk);
        xfer_valid_i  = v;
        xfer_kind_i   = k;
        link_addr_i   = a;
        restore_i     = rs;
        restore_ptr_i = 3'(rp);
        restore_cnt_i = 4'(rc);
        #2;
        exp_hit = v && (k == 2'b10) && (m_cnt > 0);
        check(AW'(ret_hit_o), AW'(exp_hit), tag, "hit");
        if (exp_hit) check(ret_target_o, m_mem[(m_ptr + D - 1) % D], tag, "target");
        check(AW'(ckpt_ptr_o), AW'(m_ptr), tag, "ptr");
        check(AW'(ckpt_cnt_o), AW'(m_cnt), tag, "cnt");
        @(posedge clk);
        if (rs) begin
            m_ptr = rp % D;
            m_cnt = (rc > D) ? D : rc;
        end else if (v && k == 2'b01) begin
            m_mem[m_ptr] = a;
            m_ptr = (m_ptr + 1) % D;
            if (m_cnt < D) m_cnt++;
        end else if (v && k == 2'b10 && m_cnt > 0) begin
            m_ptr = (m_ptr + D - 1) % D;
            m_cnt--;
        end
    endtask

    task automatic call(input logic [AW-1:0] a, input string tag);
        step(1, 2'b01, a, 0, 0, 0, tag);
    endtask

    task automatic ret(input string tag);
        step(1, 2'b10, 64'hdead, 0, 0, 0, tag);
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int sp;
        int sc;
        for (int i = 0; i < D; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        check(AW'(ckpt_ptr_o), 0, "R1", "ptr");
        check(AW'(ckpt_cnt_o), 0, "R1", "cnt");
        ret("R1");

        // R2 / R3 / R10 basic LIFO
        call(64'h1000_0004, "R2");
        call(64'h2000_0008, "R2");
        call(64'h3000_000c, "R2");
        ret("R10");
        ret("R3");

        // R5 register jump and none leave the stack alone
        step(1, 2'b11, 64'h7777, 0, 0, 0, "R5");
        step(1, 2'b00, 64'h8888, 0, 0, 0, "R5");
        step(1, 2'b11, 64'h9999, 0, 0, 0, "R5");

        // R6 valid low
        step(0, 2'b01, 64'haaaa, 0, 0, 0, "R6");
        step(0, 2'b10, 64'hbbbb, 0, 0, 0, "R6");
        ret("R3");

        // R4 empty pops
        ret("R4");
        ret("R4");

        // R7 overflow: 11 calls into 8 slots
        for (int i = 0; i < 11; i++) call(64'h4000_0000 + 64'(i * 4), "R7");
        for (int i = 0; i < 9; i++) ret("R7");

        // R8 checkpoint then restore
        call(64'h5000_0010, "R8");
        call(64'h5000_0020, "R8");
        sp = int'(ckpt_ptr_o);
        sc = int'(ckpt_cnt_o);
        call(64'h5000_0030, "R8");
        call(64'h5000_0040, "R8");
        ret("R8");
        step(0, 2'b00, 0, 1, sp, sc, "R8");
        ret("R8");
        step(0, 2'b00, 0, 1, 3, 12, "R8");
        step(0, 2'b00, 0, 1, sp, sc, "R8");

        // R9 restore beats call and return in the same cycle
        sp = int'(ckpt_ptr_o);
        sc = int'(ckpt_cnt_o);
        call(64'h6000_0100, "R9");
        step(1, 2'b01, 64'h6000_0999, 1, sp, sc, "R9");
        ret("R9");
        ret("R9");
        sp = int'(ckpt_ptr_o);
        sc = int'(ckpt_cnt_o);
        call(64'h6000_0200, "R9");
        step(1, 2'b10, 0, 1, (sp + 1) % D, sc + 1, "R9");
        ret("R9");
        ret("R9");
        for (int i = 0; i < 4; i++) ret("R4");

        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule